// File: doc/BRIEF.md
# Timer Match Output Unit

A 32-bit up-counter with four compare channels. Each channel owns a match value and a two-bit action field. When the running count equals a channel's match value, the action is applied to that channel's output pin level: hold, force low, force high or invert. The four pin levels and the four action fields sit together in one 12-bit match output register. Software reads and writes it through a simple register bus with address, write enable, write data and combinational read data.

Because levels and actions share one word, a software read-modify-write of the actions can overlap a compare event. If the stored write simply won, the hardware's pin change would be lost. The unit prevents this in two ways. First, a compare action is always applied on top of the level being written in that same cycle. Second, a write-only set mask and a write-only clear mask let software edit the action fields alone, without ever touching the levels.

A control register starts and stops the count. While it is stopped, no compare event can happen.

Top module: `tmr_match_unit`

## Requirements
- R1: After reset the control, counter, levels, action fields and match values all read as zero, and `match_o` is 0.
- R2: While control bit 0 is 1, the counter (address 1, read-only) increments by exactly one per clock. While bit 0 is 0, it holds its value.
- R3: The action field of channel n is at bits [5+2n:4+2n] of the match output register (address 2). Its codes are 00 hold, 01 drive low, 10 drive high and 11 invert. The action is applied to level bit n at the clock edge where the running counter equals channel n's match value.
- R4: While the counter is stopped, no compare event changes any level, even if a match value equals the held count.
- R5: Address 2 reads {20'b0, actions[11:4], levels[3:0]}. A write to address 2 replaces both the actions and the levels.
- R6: If a write to address 2 and a compare event on channel n fall in the same cycle, the channel's action (as it stood before the write) is applied to the written level bit n.
- R7: A write to address 3 ORs wdata[11:4] into the action fields, and a write to address 4 clears the action bits that are set in wdata[11:4]. Neither write changes any level bit, whatever wdata[3:0] holds. Both addresses read as zero.
- R8: A compare event in the same cycle as a mask write still updates its level bit, using the action as it stood before the mask write.
- R9: `match_o[n]` always equals level bit n of the match output register.
- R10: Addresses 8 to 11 hold the 32-bit match values of channels 0 to 3 and read back what was written. A write to address 1 leaves the counter unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 4 | Register word address |
| we_i | input | 1 | Write strobe, sampled on the rising edge |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Combinational read data for `addr_i` |
| match_o | output | 4 | Match output pin levels |

## Verification
The hardest case to reach from the ports is a register write that lands in exactly the clock cycle of a compare event. Free-running stimulus hits that cycle only by chance. The bench instead stops the counter, reads the held count, and programs the match values a fixed two counts ahead. It then restarts the counter and issues the level write, or the mask write, on the third edge after the start. The expected levels are chosen so that a design in which the write wins would read back a different value.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] A_CTRL = 4'd0;
  localparam logic [ADDR_W-1:0] A_CNT  = 4'd1;
  localparam logic [ADDR_W-1:0] A_OUT  = 4'd2;
  localparam logic [ADDR_W-1:0] A_SET  = 4'd3;
  localparam logic [ADDR_W-1:0] A_CLR  = 4'd4;
  localparam logic [ADDR_W-1:0] A_MV0  = 4'd8;

  typedef enum logic [1:0] {
    ACT_HOLD   = 2'b00,
    ACT_LOW    = 2'b01,
    ACT_HIGH   = 2'b10,
    ACT_INVERT = 2'b11
  } act_e;

  function automatic logic apply_act(act_e a, logic cur);
    case (a)
      ACT_LOW:    return 1'b0;
      ACT_HIGH:   return 1'b1;
      ACT_INVERT: return ~cur;
      default:    return cur;
    endcase
  endfunction
endpackage

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (run_i) cnt_q <= cnt_q + CNT_W'(1);
  end

  assign cnt_o = cnt_q;

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> $stable(cnt_q));
  p_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |=> cnt_q == $past(cnt_q) + CNT_W'(1));
endmodule

// File: rtl/tmr_cmp.sv
module tmr_cmp #(
  parameter int CNT_W = 32,
  parameter int N_CH  = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       run_i,
  input  logic [CNT_W-1:0]           cnt_i,
  input  logic [N_CH-1:0]            we_i,
  input  logic [CNT_W-1:0]           wdata_i,
  output logic [N_CH-1:0][CNT_W-1:0] mval_o,
  output logic [N_CH-1:0]            hit_o
);
  for (genvar n = 0; n < N_CH; n++) begin : g_ch
    logic [CNT_W-1:0] mv_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    mv_q <= '0;
      else if (we_i[n]) mv_q <= wdata_i;
    end

    assign mval_o[n] = mv_q;
    assign hit_o[n]  = run_i && (cnt_i == mv_q);
  end
endmodule

// File: rtl/tmr_outreg.sv
module tmr_outreg
  import tmr_pkg::*;
#(
  parameter int N_CH = 4,
  localparam int REG_W = 3 * N_CH
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              set_i,
  input  logic              clr_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic [N_CH-1:0]   hit_i,
  output logic [N_CH-1:0]   lvl_o,
  output logic [2*N_CH-1:0] act_o
);
  logic [N_CH-1:0]   lvl_q, lvl_d;
  logic [2*N_CH-1:0] act_q, act_d;
  logic [2*N_CH-1:0] wact;

  assign wact = wdata_i[REG_W-1:N_CH];

  always_comb begin
    lvl_d = lvl_q;
    act_d = act_q;
    if (wr_i) begin
      lvl_d = wdata_i[N_CH-1:0];
      act_d = wact;
    end else begin
      if (set_i) act_d = act_d | wact;
      if (clr_i) act_d = act_d & ~wact;
    end
    // compare action lands after any software level write
    for (int n = 0; n < N_CH; n++) begin
      if (hit_i[n]) lvl_d[n] = apply_act(act_e'(act_q[2*n +: 2]), lvl_d[n]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= '0;
      act_q <= '0;
    end else begin
      lvl_q <= lvl_d;
      act_q <= act_d;
    end
  end

  assign lvl_o = lvl_q;
  assign act_o = act_q;

  p_lvl_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i && hit_i == '0 |=> $stable(lvl_q));
  p_mask_keeps_lvl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i || clr_i) && !wr_i && hit_i == '0 |=> $stable(lvl_q));

  for (genvar n = 0; n < N_CH; n++) begin : g_chk
    p_wr_hit_high_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_i && hit_i[n] && act_q[2*n +: 2] == ACT_HIGH |=> lvl_q[n]);
    p_wr_hit_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_i && hit_i[n] && act_q[2*n +: 2] == ACT_LOW |=> !lvl_q[n]);
  end
endmodule

// File: rtl/tmr_match_unit.sv
module tmr_match_unit
  import tmr_pkg::*;
#(
  parameter int DW    = 32,
  parameter int CNT_W = 32,
  parameter int N_CH  = 4,
  localparam int REG_W = 3 * N_CH
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic [N_CH-1:0]   match_o
);
  logic                       run_q;
  logic [CNT_W-1:0]           cnt;
  logic [N_CH-1:0][CNT_W-1:0] mval;
  logic [N_CH-1:0]            hit;
  logic [N_CH-1:0]            mv_we;
  logic [N_CH-1:0]            lvl;
  logic [2*N_CH-1:0]          act;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        run_q <= 1'b0;
    else if (we_i && addr_i == A_CTRL) run_q <= wdata_i[0];
  end

  for (genvar n = 0; n < N_CH; n++) begin : g_dec
    assign mv_we[n] = we_i && (addr_i == A_MV0 + ADDR_W'(n));
  end

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .run_i(run_q), .cnt_o(cnt)
  );

  tmr_cmp #(.CNT_W(CNT_W), .N_CH(N_CH)) u_cmp (
    .clk_i, .rst_ni, .run_i(run_q), .cnt_i(cnt), .we_i(mv_we),
    .wdata_i(wdata_i[CNT_W-1:0]), .mval_o(mval), .hit_o(hit)
  );

  tmr_outreg #(.N_CH(N_CH)) u_out (
    .clk_i, .rst_ni,
    .wr_i(we_i && addr_i == A_OUT),
    .set_i(we_i && addr_i == A_SET),
    .clr_i(we_i && addr_i == A_CLR),
    .wdata_i(wdata_i[REG_W-1:0]),
    .hit_i(hit), .lvl_o(lvl), .act_o(act)
  );

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CTRL:  rdata_o = DW'(run_q);
      A_CNT:   rdata_o = DW'(cnt);
      A_OUT:   rdata_o = DW'({act, lvl});
      default: begin
        for (int n = 0; n < N_CH; n++)
          if (addr_i == A_MV0 + ADDR_W'(n)) rdata_o = DW'(mval[n]);
      end
    endcase
  end

  assign match_o = lvl;
endmodule

// File: tb/sim_tmr_match_unit.sv
`timescale 1ns/1ps
module sim_tmr_match_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  match;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tmr_match_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we),
    .wdata_i(wdata), .rdata_o(rdata), .match_o(match)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(posedge clk);
    #1 we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    @(negedge clk);
    addr = a;
    #1 v = rdata;
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(4'd0, v);  chk("R1 ctrl", v, 0);
    rd(4'd1, v);  chk("R1 counter", v, 0);
    rd(4'd2, v);  chk("R1 outreg", v, 0);
    rd(4'd9, v);  chk("R1 match value", v, 0);
    chk("R1 match_o", 32'(match), 0);
    tick(5);
    rd(4'd1, v);  chk("R2 counter idle after reset", v, 0);
  endtask

  task automatic t_map();
    logic [31:0] v;
    for (int n = 0; n < 4; n++) wr(4'(8 + n), 32'hA5A50000 + 32'(n));
    for (int n = 0; n < 4; n++) begin
      rd(4'(8 + n), v);
      chk("R10 match value readback", v, 32'hA5A50000 + 32'(n));
    end
    wr(4'd1, 32'h55);
    rd(4'd1, v);  chk("R10 counter not writable", v, 0);
    wr(4'd3, 32'h0);
    rd(4'd3, v);  chk("R7 set mask reads zero", v, 0);
    rd(4'd4, v);  chk("R7 clear mask reads zero", v, 0);
  endtask

  task automatic t_count();
    logic [31:0] a, b;
    wr(4'd0, 1);
    rd(4'd0, a);  chk("R2 ctrl readback", a, 1);
    rd(4'd1, a);
    tick(10);
    rd(4'd1, b);  chk("R2 ten increments", b - a, 10);
    wr(4'd0, 0);
    rd(4'd1, a);
    tick(10);
    rd(4'd1, b);  chk("R2 holds when stopped", b, a);
  endtask

  task automatic t_actions();
    logic [31:0] c, v;
    rd(4'd1, c);
    for (int n = 0; n < 4; n++) wr(4'(8 + n), c + 5);
    // ch0 high, ch1 low, ch2 invert, ch3 hold; levels 1010
    wr(4'd2, 32'h36A);
    rd(4'd2, v);  chk("R5 outreg write readback", v, 32'h36A);
    wr(4'd0, 1);
    tick(20);
    wr(4'd0, 0);
    rd(4'd2, v);  chk("R3 four action codes", v, 32'h36D);
    chk("R9 pins follow levels", 32'(match), 32'hD);
  endtask

  task automatic t_stopped();
    logic [31:0] c, v;
    rd(4'd1, c);
    wr(4'd10, c);
    tick(5);
    rd(4'd2, v);  chk("R4 no event while stopped", v, 32'h36D);
  endtask

  task automatic t_collision();
    logic [31:0] c, v;
    rd(4'd1, c);
    wr(4'd2, 32'h0B0);   // ch0 invert, ch1 high, levels 0
    for (int n = 0; n < 4; n++) wr(4'(8 + n), c + 2);
    wr(4'd0, 1);
    tick(2);
    wr(4'd2, 32'h0B4);   // lands on the compare edge
    wr(4'd0, 0);
    rd(4'd2, v);  chk("R6 compare applied over written level", v, 32'h0B7);
    chk("R9 pins after collision", 32'(match), 32'h7);
  endtask

  task automatic t_mask();
    logic [31:0] v;
    wr(4'd3, 32'h0F8);
    rd(4'd2, v);  chk("R7 set mask", v, 32'h0F7);
    wr(4'd4, 32'h037);
    rd(4'd2, v);  chk("R7 clear mask", v, 32'h0C7);
  endtask

  task automatic t_mask_collision();
    logic [31:0] c, v;
    rd(4'd1, c);
    wr(4'd9, c + 2);     // ch1 invert
    wr(4'd0, 1);
    tick(2);
    wr(4'd3, 32'h100);   // set ch2 low-code bit on the compare edge
    wr(4'd0, 0);
    rd(4'd2, v);  chk("R8 mask write with compare", v, 32'h1C5);
    chk("R9 pins after mask collision", 32'(match), 32'h5);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_map();
    t_count();
    t_actions();
    t_stopped();
    t_collision();
    t_mask();
    t_mask_collision();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule